// File: doc/BRIEF.md
# Microcontroller R/D Port Bank

This block holds the general-purpose I/O state of a small 4-bit microcontroller core. It keeps eleven indexed nibble-wide port latches (indices 0 to 9 are full 4-bit ports; index 10 is a 2-bit port) and one 16-line discrete port that the core reaches one bit at a time. Every line carries a fixed mask value that marks it as a pull-down line (mask set) or a high-voltage line (mask clear). The mask decides how the pin level and the latch are merged when the core reads the line.

The core writes a nibble port with an index and 4 bits of data. It reads a nibble port through the same index, and the result is combinational. For the discrete port the core sets or clears one latch bit by bit index and tests one bit combinationally. On the pin side, each port has an input bus with a per-port "driven" flag, and a latch output bus. A port whose driven flag is low reads its own mask value as its pin level. Reads from output-only or unknown indices return all ones and raise an error flag. Writes to indices above 8 are dropped.

Top module: `gpio_port_bank`

## Requirements
- R1: A read of index 10 returns the resolved value with bits 3:2 forced to 0.
- R2: A read of index 0, 6, 7, 8 or any index from 11 to 15 returns 4'hF with `r_rd_bad` high. For every other index `r_rd_bad` is low.
- R3: A write with index 0 to 8 stores the 4 data bits into that port's latch. The latch appears on `r_latch_out[4i+3:4i]` one clock after the write. A write with index 9 to 15 leaves every latch unchanged.
- R4: After reset, `d_latch_out` equals 16'h000F. Lines 0 to 3 have mask 1 and lines 4 to 15 have mask 0.
- R5: After reset, ports 3 to 9 hold latch 4'hF with mask 4'hF. Ports 0, 1, 2 and 10 hold latch 0 with mask 0.
- R6: A valid nibble read returns pin AND latch when the port's mask is nonzero, and pin OR latch when the mask is zero.
- R7: A discrete write changes only the latch bit chosen by `d_bit`, setting it to `d_wr_val`, one clock later.
- R8: `d_test` is bit `d_bit` of (pin AND latch) when that line's mask bit is 1, and of (pin OR latch) when it is 0.
- R9: When a port's driven flag is low (`r_pin_drive[i]`, or `d_pin_drive` for the discrete port), its pin value is taken to be its mask value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| r_idx | input | 4 | Nibble port index for read and write |
| r_wr_en | input | 1 | Nibble write strobe |
| r_wr_data | input | 4 | Nibble write data |
| r_rd_data | output | 4 | Resolved read value of port `r_idx` |
| r_rd_bad | output | 1 | Read of an output-only or unknown index |
| d_bit | input | 4 | Discrete line index |
| d_wr_en | input | 1 | Discrete write strobe |
| d_wr_val | input | 1 | Value written to the selected line |
| d_test | output | 1 | Resolved value of the selected line |
| r_pin_in | input | 44 | Pin levels, port i at bits 4i+3:4i |
| r_pin_drive | input | 11 | Port i pins are driven externally |
| r_latch_out | output | 44 | Latch values, port i at bits 4i+3:4i |
| d_pin_in | input | 16 | Discrete pin levels |
| d_pin_drive | input | 1 | Discrete pins are driven externally |
| d_latch_out | output | 16 | Discrete latch values |

## Verification
Every index from 0 to 15 is read three times: with the pins undriven, with pins 4'h5, and with pins 4'hA. Undriven reads show the mask default. The two complementary pin values separate AND merging from OR merging on pull-down and high-voltage ports, and also show the 2-bit trim on index 10. Writes of distinct values to every index, including 9 to 15, separate stored writes from dropped ones. Each discrete bit is set and cleared in turn with the other bits watched, and is tested with pins driven both ways. A long pseudo-random run then mixes all of these against the reference model.

// File: rtl/gpio_port_bank.sv
module gpio_port_bank #(
  parameter int NR = 11,
  parameter int RW = 4,
  parameter int DW = 16,
  parameter int XW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [XW-1:0]    r_idx,
  input  logic             r_wr_en,
  input  logic [RW-1:0]    r_wr_data,
  output logic [RW-1:0]    r_rd_data,
  output logic             r_rd_bad,
  input  logic [$clog2(DW)-1:0] d_bit,
  input  logic             d_wr_en,
  input  logic             d_wr_val,
  output logic             d_test,
  input  logic [NR*RW-1:0] r_pin_in,
  input  logic [NR-1:0]    r_pin_drive,
  output logic [NR*RW-1:0] r_latch_out,
  input  logic [DW-1:0]    d_pin_in,
  input  logic             d_pin_drive,
  output logic [DW-1:0]    d_latch_out
);
  localparam logic [DW-1:0] DMASK = DW'(16'h000F);
  localparam int LAST_WR = 8;
  localparam int NARROW = 10;

  function automatic logic [RW-1:0] mask_of(int i);
    return (i >= 3 && i <= 9) ? {RW{1'b1}} : '0;
  endfunction

  logic [RW-1:0] lat [NR];
  logic [RW-1:0] pin [NR];
  logic [RW-1:0] msk [NR];
  logic [DW-1:0] dlat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NR; i++) lat[i] <= mask_of(i);
      dlat <= DMASK;
    end else begin
      if (r_wr_en && int'(r_idx) <= LAST_WR) lat[r_idx] <= r_wr_data;
      if (d_wr_en) dlat[d_bit] <= d_wr_val;
    end
  end

  for (genvar i = 0; i < NR; i++) begin : g_port
    assign msk[i] = mask_of(i);
    assign pin[i] = r_pin_drive[i] ? r_pin_in[i*RW +: RW] : msk[i];
    assign r_latch_out[i*RW +: RW] = lat[i];
  end

  logic          in_rng;
  logic [RW-1:0] s_lat, s_pin, s_msk, merged;
  assign in_rng = int'(r_idx) < NR;
  assign s_lat  = in_rng ? lat[r_idx] : '0;
  assign s_pin  = in_rng ? pin[r_idx] : '0;
  assign s_msk  = in_rng ? msk[r_idx] : '0;
  assign merged = (s_msk != 0) ? (s_pin & s_lat) : (s_pin | s_lat);

  assign r_rd_bad = !in_rng || r_idx == 0 || (int'(r_idx) >= 6 && int'(r_idx) <= LAST_WR);
  assign r_rd_data = r_rd_bad ? {RW{1'b1}} :
                     (int'(r_idx) == NARROW) ? (merged & RW'(2'b11)) : merged;

  logic [DW-1:0] dpin;
  assign dpin = d_pin_drive ? d_pin_in : DMASK;
  assign d_test = DMASK[d_bit] ? (dpin[d_bit] & dlat[d_bit]) : (dpin[d_bit] | dlat[d_bit]);
  assign d_latch_out = dlat;
endmodule

// File: rtl/gpio_port_bank_chk.sv
module gpio_port_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  r_idx,
  input logic        r_wr_en,
  input logic [3:0]  r_wr_data,
  input logic [3:0]  r_rd_data,
  input logic        r_rd_bad,
  input logic [3:0]  d_bit,
  input logic        d_wr_en,
  input logic        d_wr_val,
  input logic [43:0] r_latch_out,
  input logic [15:0] d_latch_out
);
  function automatic logic [3:0] nib(logic [43:0] v, logic [3:0] i);
    return (i < 11) ? v[i*4 +: 4] : 4'h0;
  endfunction

  p_bad_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    r_rd_bad |-> r_rd_data == 4'hF);
  p_narrow_port_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (r_idx == 4'd10) |-> r_rd_data[3:2] == 2'b00);
  p_write_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (r_wr_en && r_idx > 4'd8) |=> $stable(r_latch_out));
  p_write_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (r_wr_en && r_idx <= 4'd8) |=> nib(r_latch_out, $past(r_idx)) == $past(r_wr_data));
  p_d_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> d_latch_out == 16'h000F);
  p_d_single_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    d_wr_en |=> ((d_latch_out ^ $past(d_latch_out)) & ~(16'h1 << $past(d_bit))) == 16'h0);
  p_d_bit_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
    d_wr_en |=> d_latch_out[$past(d_bit)] == $past(d_wr_val));
endmodule

bind gpio_port_bank gpio_port_bank_chk chk_i (
  .clk(clk), .rst_n(rst_n), .r_idx(r_idx), .r_wr_en(r_wr_en), .r_wr_data(r_wr_data),
  .r_rd_data(r_rd_data), .r_rd_bad(r_rd_bad), .d_bit(d_bit), .d_wr_en(d_wr_en),
  .d_wr_val(d_wr_val), .r_latch_out(r_latch_out), .d_latch_out(d_latch_out)
);

// File: tb/gpio_port_bank_tb_top.sv
module gpio_port_bank_tb_top;
  logic clk = 0, rst_n = 0;
  logic [3:0] r_idx = 0, r_wr_data = 0, d_bit = 0;
  logic r_wr_en = 0, d_wr_en = 0, d_wr_val = 0, d_pin_drive = 0;
  logic [43:0] r_pin_in = 0;
  logic [10:0] r_pin_drive = 0;
  logic [15:0] d_pin_in = 0;
  logic [3:0] r_rd_data;
  logic r_rd_bad, d_test;
  logic [43:0] r_latch_out;
  logic [15:0] d_latch_out;

  always #10 clk = ~clk;

  gpio_port_bank dut_i (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  int mlat [11];
  int dlat;

  function automatic int pmask(int i);
    return (i >= 3 && i <= 9) ? 15 : 0;
  endfunction

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (idx %0d bit %0d)", tag, got, exp, r_idx, d_bit);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 11; i++) mlat[i] = pmask(i);
    dlat = 16'h000F;
  endtask

  task automatic compare();
    int i, p, v, b, dp, bad;
    i = r_idx;
    bad = (i == 0 || (i >= 6 && i <= 8) || i > 10);
    chk("R2 bad flag", r_rd_bad, bad);
    if (bad) chk("R2 bad data", r_rd_data, 15);
    else begin
      p = r_pin_drive[i] ? int'(r_pin_in[i*4 +: 4]) : pmask(i);
      v = pmask(i) != 0 ? (p & mlat[i]) : (p | mlat[i]);
      if (i == 10) chk("R1 narrow read", r_rd_data, v & 3);
      else if (!r_pin_drive[i]) chk("R9 default pin read", r_rd_data, v);
      else chk("R6 merged read", r_rd_data, v);
    end
    b = d_bit;
    dp = d_pin_drive ? int'(d_pin_in[b]) : (b < 4 ? 1 : 0);
    v = (b < 4) ? (dp & ((dlat >> b) & 1)) : (dp | ((dlat >> b) & 1));
    chk(d_pin_drive ? "R8 d test" : "R9 d test default", d_test, v);
    for (int k = 0; k < 11; k++) chk("R3 latch", r_latch_out[k*4 +: 4], mlat[k]);
    chk("R7 d latch", d_latch_out, dlat);
  endtask

  task automatic step();
    #5 compare();
    @(posedge clk);
    if (r_wr_en && r_idx <= 8) mlat[r_idx] = r_wr_data;
    if (d_wr_en) dlat = d_wr_val ? (dlat | (1 << d_bit)) : (dlat & ~(1 << d_bit));
    @(negedge clk);
    r_wr_en = 0; d_wr_en = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] lf;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #5;
    chk("R4 d reset", d_latch_out, 16'h000F);
    for (int k = 0; k < 11; k++) chk("R5 r reset", r_latch_out[k*4 +: 4], pmask(k));
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin r_idx = 4'(i); step(); end
    r_pin_drive = '1;
    r_pin_in = {11{4'h5}};
    for (int i = 0; i < 16; i++) begin r_idx = 4'(i); step(); end
    r_pin_in = {11{4'hA}};
    for (int i = 0; i < 16; i++) begin r_idx = 4'(i); step(); end
    for (int i = 0; i < 16; i++) begin
      r_idx = 4'(i); r_wr_data = 4'(i ^ 6); r_wr_en = 1; step();
      r_idx = 4'(i); step();
    end
    for (int b = 0; b < 16; b++) begin
      d_bit = 4'(b); d_wr_val = ~dlat[b]; d_wr_en = 1; step();
      d_pin_drive = 1; d_pin_in = 16'h0000; step();
      d_pin_in = 16'hFFFF; step();
      d_pin_drive = 0; step();
    end
    lf = 32'h1234_5678;
    for (int n = 0; n < 2000; n++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      r_idx = lf[3:0]; r_wr_data = lf[7:4]; r_wr_en = lf[8];
      d_bit = lf[12:9]; d_wr_val = lf[13]; d_wr_en = lf[14];
      d_pin_drive = lf[15]; d_pin_in = lf[31:16];
      r_pin_drive = 11'(lf[26:16] ^ lf[10:0]);
      r_pin_in = {lf[11:0], lf, lf[31:20] ^ lf[11:0]} ^ 44'(n);
      step();
    end
    finish_run();
  end
endmodule